// File: doc/BRIEF.md
# SPI Register Access Command Decoder

This block is an SPI target (clock polarity 0, phase 0) that gives a host controller byte-wide access to a flat register file with 8-bit addresses. The host pulls chip select low and sends one command byte, then one address byte. After that it sends any number of data bytes. After every data byte the working address steps up by one, so a single transaction can sweep a whole region.

Four commands are recognised: read, write, bit-set and bit-clear. The block drives a simple register-file port made of an address, a byte of write data or mask, and three one-cycle strobes: write, set and clear. The register file performs the OR or AND-NOT itself, using the mask. Read data comes back on a combinational read bus and is shifted out MSB first. Two address classes get special treatment. A few data-window addresses are left alone by every command and read back as zero. A reserved range refuses bit-set and bit-clear but still accepts plain writes.

The SPI pins are sampled with the system clock through a synchroniser. The SPI clock must therefore be slow compared with the system clock.

Top module: `spi_reg_port`

## Requirements
- R1: The command byte is taken MSB first. 20h means read, 22h means write, 24h means bit-set and 26h means bit-clear. Any other value makes the rest of the transaction inert: no strobes, and MISO stays low until chip select rises.
- R2: The second byte of a transaction is the start address. Every byte after it is a data byte, and a transaction may carry any number of them.
- R3: After each data byte the working address increases by one and wraps from FFh to 00h.
- R4: Each complete data byte of a write command gives exactly one `regWrEn` pulse. The pulse carries the current address and that byte on `regWrData`.
- R5: Each complete data byte of a bit-set command gives one `regSetEn` pulse, and of a bit-clear command one `regClrEn` pulse. The pulse carries the byte as a mask on `regWrData`. The bits set to 1 in the mask are ORed in (set) or cleared (clear). All other bits stay as they were.
- R6: Bit-set and bit-clear give no strobe for addresses 80h through 9Fh. Writes to that range still take effect.
- R7: The data-window addresses 50h, 52h and 54h never receive any strobe. A read of them returns 00h. The address still advances past them.
- R8: During a read, each data-byte slot shifts out, MSB first, the register at that slot's address. The first bit is valid before the first rising SCLK edge of the slot. MISO is low during the command and address bytes, during every non-read data byte, and whenever chip select is high.
- R9: When chip select rises, the transaction ends. A partially received data byte is discarded without a strobe, and the next transaction starts again with a command byte.
- R10: Strobes last one system clock cycle. At most one strobe is active at a time, and none is active while chip select is high or during reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| spiCsN | input | 1 | SPI chip select, active low |
| spiSclk | input | 1 | SPI clock, idles low |
| spiMosi | input | 1 | Serial data from host |
| spiMiso | output | 1 | Serial data to host |
| regAddr | output | 8 | Register file address |
| regWrData | output | 8 | Write data or bit mask |
| regWrEn | output | 1 | Write strobe |
| regSetEn | output | 1 | Bit-set strobe (OR mask) |
| regClrEn | output | 1 | Bit-clear strobe (AND-NOT mask) |
| regRdData | input | 8 | Combinational read data at regAddr |

## Verification
Some properties are checked on every cycle by the assertions:
- strobes are one cycle long, exclusive, and never active while chip select is high;
- the address steps by exactly one after every strobe;
- no strobe ever lands on a window address;
- no set or clear strobe reaches the reserved range;
- MISO is quiet while deselected;
- an unrecognised command leaves the port inert.

The bench covers what only whole scenarios can show. It runs full 256-address write and read sweeps through the wrap point. It sweeps set and clear masks across the edges of the reserved range. It sends an unknown command, and it aborts a transaction mid-byte. After each, it compares the register contents and the shifted-out bytes with values computed arithmetically.

// File: rtl/spi_reg_pkg.sv
package spi_reg_pkg;

  localparam int BYTE_W = 8;

  typedef enum logic [BYTE_W-1:0] {
    OP_RD  = 8'h20,
    OP_WR  = 8'h22,
    OP_SET = 8'h24,
    OP_CLR = 8'h26
  } spiOp_e;

  typedef enum logic [1:0] {
    PH_OPC,
    PH_ADR,
    PH_DAT,
    PH_SKIP
  } phase_e;

  // control -> datapath strobes
  typedef struct packed {
    logic captAddr;
    logic incAddr;
    logic loadTx;
    logic txFromReg;
  } dpCtl_t;

  // datapath -> control status
  typedef struct packed {
    logic              csIdle;
    logic              byteDone;
    logic [BYTE_W-1:0] rxByte;
    logic              addrIsWin;
    logic              addrIsRsv;
  } dpStat_t;

endpackage

// File: rtl/spi_reg_dpath.sv
module spi_reg_dpath
  import spi_reg_pkg::*;
#(
  parameter int                      SYNC_STAGES = 2,
  parameter int                      NUM_WIN     = 3,
  parameter logic [NUM_WIN*BYTE_W-1:0] WIN_LIST  = {8'h54, 8'h52, 8'h50},
  parameter logic [BYTE_W-1:0]       RSV_LO      = 8'h80,
  parameter logic [BYTE_W-1:0]       RSV_HI      = 8'h9F
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              spiCsN,
  input  logic              spiSclk,
  input  logic              spiMosi,
  input  dpCtl_t            ctl,
  input  logic [BYTE_W-1:0] regRdData,
  output dpStat_t           stat,
  output logic [BYTE_W-1:0] addrQ,
  output logic              spiMiso
);

  localparam int CNT_W = $clog2(BYTE_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

  logic [SYNC_STAGES-1:0] csChain, sclkChain, mosiChain;

  generate
    if (SYNC_STAGES == 1) begin : g_syncOne
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          csChain   <= '1;
          sclkChain <= '0;
          mosiChain <= '0;
        end else begin
          csChain   <= spiCsN;
          sclkChain <= spiSclk;
          mosiChain <= spiMosi;
        end
      end
    end else begin : g_syncMulti
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          csChain   <= '1;
          sclkChain <= '0;
          mosiChain <= '0;
        end else begin
          csChain   <= {csChain[SYNC_STAGES-2:0], spiCsN};
          sclkChain <= {sclkChain[SYNC_STAGES-2:0], spiSclk};
          mosiChain <= {mosiChain[SYNC_STAGES-2:0], spiMosi};
        end
      end
    end
  endgenerate

  logic csS, sclkS, mosiS, sclkQ;
  assign csS   = csChain[SYNC_STAGES-1];
  assign sclkS = sclkChain[SYNC_STAGES-1];
  assign mosiS = mosiChain[SYNC_STAGES-1];

  logic sclkRise, sclkFall;
  assign sclkRise = sclkS & ~sclkQ & ~csS;
  assign sclkFall = ~sclkS & sclkQ & ~csS;

  logic [CNT_W-1:0]  bitCnt;
  logic [BYTE_W-1:0] rxSh, txSh;
  logic              byteDone, skipFall;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclkQ    <= 1'b0;
      bitCnt   <= '0;
      rxSh     <= '0;
      txSh     <= '0;
      byteDone <= 1'b0;
      skipFall <= 1'b0;
    end else begin
      sclkQ <= sclkS;
      if (csS) begin
        bitCnt   <= '0;
        txSh     <= '0;
        byteDone <= 1'b0;
        skipFall <= 1'b0;
      end else begin
        byteDone <= sclkRise && (bitCnt == LAST_BIT);
        if (sclkRise) begin
          rxSh   <= {rxSh[BYTE_W-2:0], mosiS};
          bitCnt <= bitCnt + 1'b1;
        end
        if (ctl.loadTx) begin
          txSh     <= ctl.txFromReg ? regRdData : '0;
          skipFall <= 1'b1;
        end else if (sclkFall) begin
          if (skipFall) skipFall <= 1'b0;
          else          txSh     <= {txSh[BYTE_W-2:0], 1'b0};
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             addrQ <= '0;
    else if (ctl.captAddr) addrQ <= rxSh;
    else if (ctl.incAddr)  addrQ <= addrQ + 1'b1;
  end

  logic [NUM_WIN-1:0] winHit;
  generate
    for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
      assign winHit[w] = (addrQ == WIN_LIST[w*BYTE_W +: BYTE_W]);
    end
  endgenerate

  assign stat.csIdle    = csS;
  assign stat.byteDone  = byteDone;
  assign stat.rxByte    = rxSh;
  assign stat.addrIsWin = |winHit;
  assign stat.addrIsRsv = (addrQ >= RSV_LO) && (addrQ <= RSV_HI);

  assign spiMiso = txSh[BYTE_W-1];

  // R8
  miso_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (csS && $past(csS)) |-> !spiMiso);

  // R8
  miso_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!$past(csS) && !$past(sclkFall) && !$past(ctl.loadTx) && !csS) |-> $stable(spiMiso));

endmodule

// File: rtl/spi_reg_ctrl.sv
module spi_reg_ctrl
  import spi_reg_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  dpStat_t stat,
  output dpCtl_t  ctl,
  output logic    regWrEn,
  output logic    regSetEn,
  output logic    regClrEn
);

  phase_e phase;
  spiOp_e opQ;
  logic   loadPend;

  function automatic logic knownOp(input logic [BYTE_W-1:0] b);
    return (b == OP_RD) || (b == OP_WR) || (b == OP_SET) || (b == OP_CLR);
  endfunction

  logic dataDone;
  assign dataDone = !stat.csIdle && stat.byteDone && (phase == PH_DAT);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase    <= PH_OPC;
      opQ      <= OP_RD;
      loadPend <= 1'b0;
    end else if (stat.csIdle) begin
      phase    <= PH_OPC;
      loadPend <= 1'b0;
    end else begin
      loadPend <= stat.byteDone && ((phase == PH_ADR) || (phase == PH_DAT));
      if (stat.byteDone) begin
        unique case (phase)
          PH_OPC: begin
            if (knownOp(stat.rxByte)) begin
              opQ   <= spiOp_e'(stat.rxByte);
              phase <= PH_ADR;
            end else begin
              phase <= PH_SKIP;
            end
          end
          PH_ADR:  phase <= PH_DAT;
          PH_DAT:  phase <= PH_DAT;
          PH_SKIP: phase <= PH_SKIP;
        endcase
      end
    end
  end

  always_comb begin
    ctl          = '0;
    regWrEn      = 1'b0;
    regSetEn     = 1'b0;
    regClrEn     = 1'b0;
    ctl.captAddr = !stat.csIdle && stat.byteDone && (phase == PH_ADR);
    ctl.incAddr  = dataDone;
    ctl.loadTx   = loadPend;
    ctl.txFromReg = (opQ == OP_RD) && !stat.addrIsWin;
    if (dataDone && !stat.addrIsWin) begin
      unique case (opQ)
        OP_WR:   regWrEn  = 1'b1;
        OP_SET:  regSetEn = !stat.addrIsRsv;
        OP_CLR:  regClrEn = !stat.addrIsRsv;
        default: ;
      endcase
    end
  end

  logic anyStrobe;
  assign anyStrobe = regWrEn | regSetEn | regClrEn;

  // R1
  skip_inert_chk: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_SKIP) |-> (!anyStrobe && !ctl.loadTx));

  // R10
  strobe_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    anyStrobe |=> !anyStrobe);

  // R10
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({regWrEn, regSetEn, regClrEn}));

  // R10
  strobe_cs_chk: assert property (@(posedge clk) disable iff (!rstN)
    anyStrobe |-> !stat.csIdle);

endmodule

// File: rtl/spi_reg_port.sv
module spi_reg_port
  import spi_reg_pkg::*;
#(
  parameter int                        SYNC_STAGES = 2,
  parameter int                        NUM_WIN     = 3,
  parameter logic [NUM_WIN*BYTE_W-1:0] WIN_LIST    = {8'h54, 8'h52, 8'h50},
  parameter logic [BYTE_W-1:0]         RSV_LO      = 8'h80,
  parameter logic [BYTE_W-1:0]         RSV_HI      = 8'h9F
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              spiCsN,
  input  logic              spiSclk,
  input  logic              spiMosi,
  output logic              spiMiso,
  output logic [BYTE_W-1:0] regAddr,
  output logic [BYTE_W-1:0] regWrData,
  output logic              regWrEn,
  output logic              regSetEn,
  output logic              regClrEn,
  input  logic [BYTE_W-1:0] regRdData
);

  dpCtl_t  ctl;
  dpStat_t stat;

  spi_reg_dpath #(
    .SYNC_STAGES(SYNC_STAGES),
    .NUM_WIN    (NUM_WIN),
    .WIN_LIST   (WIN_LIST),
    .RSV_LO     (RSV_LO),
    .RSV_HI     (RSV_HI)
  ) uDpath (
    .clk      (clk),
    .rstN     (rstN),
    .spiCsN   (spiCsN),
    .spiSclk  (spiSclk),
    .spiMosi  (spiMosi),
    .ctl      (ctl),
    .regRdData(regRdData),
    .stat     (stat),
    .addrQ    (regAddr),
    .spiMiso  (spiMiso)
  );

  spi_reg_ctrl uCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .stat    (stat),
    .ctl     (ctl),
    .regWrEn (regWrEn),
    .regSetEn(regSetEn),
    .regClrEn(regClrEn)
  );

  assign regWrData = stat.rxByte;

  // independent window check on the port address
  logic winChk;
  always_comb begin
    winChk = 1'b0;
    for (int w = 0; w < NUM_WIN; w++)
      if (regAddr == WIN_LIST[w*BYTE_W +: BYTE_W]) winChk = 1'b1;
  end

  // R7
  win_untouched_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn || regSetEn || regClrEn) |-> !winChk);

  // R6
  rsv_noset_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regSetEn || regClrEn) |-> !((regAddr >= RSV_LO) && (regAddr <= RSV_HI)));

  // R3
  addr_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn || regSetEn || regClrEn) |=> (regAddr == $past(regAddr) + 8'd1));

endmodule

// File: tb/spi_reg_port_test.sv
module spi_reg_port_test;

  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 6;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic spiCsN = 1'b1, spiSclk = 1'b0, spiMosi = 1'b0;
  logic spiMiso;
  logic [7:0] regAddr, regWrData, regRdData;
  logic regWrEn, regSetEn, regClrEn;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_reg_port uut (
    .clk(clk), .rstN(rstN), .spiCsN(spiCsN), .spiSclk(spiSclk), .spiMosi(spiMosi),
    .spiMiso(spiMiso), .regAddr(regAddr), .regWrData(regWrData), .regWrEn(regWrEn),
    .regSetEn(regSetEn), .regClrEn(regClrEn), .regRdData(regRdData)
  );

  // register file environment
  logic [7:0] rfMem [256];
  int strobeCnt;
  assign regRdData = rfMem[regAddr];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < 256; i++) rfMem[i] <= 8'h00;
      strobeCnt <= 0;
    end else begin
      if (regWrEn)  rfMem[regAddr] <= regWrData;
      if (regSetEn) rfMem[regAddr] <= rfMem[regAddr] | regWrData;
      if (regClrEn) rfMem[regAddr] <= rfMem[regAddr] & ~regWrData;
      if (regWrEn || regSetEn || regClrEn) strobeCnt <= strobeCnt + 1;
    end
  end

  logic [7:0] expMem [256];
  int total = 0, bad = 0;
  bit done = 0;

  function automatic bit isWin(input logic [7:0] a);
    return (a == 8'h50) || (a == 8'h52) || (a == 8'h54);
  endfunction

  function automatic bit isRsv(input logic [7:0] a);
    return (a >= 8'h80) && (a <= 8'h9F);
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  task automatic spiByte(input logic [7:0] txB, input int nBits, output logic [7:0] rxB);
    rxB = 8'h00;
    for (int i = 0; i < nBits; i++) begin
      spiMosi = txB[7-i];
      repeat (HALF) @(negedge clk);
      rxB = {rxB[6:0], spiMiso};
      spiSclk = 1'b1;
      repeat (HALF) @(negedge clk);
      spiSclk = 1'b0;
    end
  endtask

  task automatic csStart();
    @(negedge clk);
    spiCsN = 1'b0;
    repeat (HALF) @(negedge clk);
  endtask

  task automatic csStop();
    repeat (HALF) @(negedge clk);
    spiCsN = 1'b1;
    repeat (10) @(negedge clk);
  endtask

  // header: command + address, both slots must read back zero (R8)
  task automatic sendHeader(input logic [7:0] op, input logic [7:0] adr);
    logic [7:0] r;
    spiByte(op, 8, r);
    check(r == 8'h00, "R8 miso low in command byte", r, 0);
    spiByte(adr, 8, r);
    check(r == 8'h00, "R8 miso low in address byte", r, 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=running expected=finished");
    finishRun();
  end

  initial begin
    logic [7:0] r, a, d;
    int sc;
    for (int i = 0; i < 256; i++) expMem[i] = 8'h00;
    repeat (10) @(negedge clk);
    rstN = 1'b1;
    repeat (5) @(negedge clk);
    check(spiMiso == 1'b0, "R8 reset miso", spiMiso, 0);
    check({regWrEn, regSetEn, regClrEn} == 3'b000, "R10 reset strobes",
          {regWrEn, regSetEn, regClrEn}, 0);

    // write sweep: all 256 addresses from F0h with wrap (R2 R3 R4 R7)
    csStart();
    sendHeader(8'h22, 8'hF0);
    for (int i = 0; i < 256; i++) begin
      a = 8'(8'hF0 + i);
      d = 8'(a * 8'd37 + 8'd11);
      spiByte(d, 8, r);
      check(r == 8'h00, "R8 miso low in write data", r, 0);
      if (!isWin(a)) expMem[a] = d;
    end
    csStop();
    for (int i = 0; i < 256; i++)
      check(rfMem[i] == expMem[i], "R4 R3 R7 write sweep", rfMem[i], expMem[i]);
    check(strobeCnt == 253, "R7 window writes produce no strobe", strobeCnt, 253);

    // read sweep from 10h with wrap (R8 R3 R7)
    csStart();
    sendHeader(8'h20, 8'h10);
    for (int i = 0; i < 256; i++) begin
      a = 8'(8'h10 + i);
      spiByte(8'hFF, 8, r);
      check(r == (isWin(a) ? 8'h00 : expMem[a]), "R8 R3 R7 read sweep", r,
            isWin(a) ? 0 : expMem[a]);
    end
    csStop();

    // bit-set across reserved-range edges (R5 R6)
    sc = strobeCnt;
    csStart();
    sendHeader(8'h24, 8'h70);
    for (int i = 0; i < 64; i++) begin
      a = 8'(8'h70 + i);
      d = 8'(a ^ 8'hC3);
      spiByte(d, 8, r);
      if (!isWin(a) && !isRsv(a)) expMem[a] = expMem[a] | d;
    end
    csStop();
    for (int i = 8'h70; i < 8'hB0; i++)
      check(rfMem[i] == expMem[i], "R5 R6 bit-set sweep", rfMem[i], expMem[i]);
    check(strobeCnt - sc == 32, "R6 set strobes outside reserved range", strobeCnt - sc, 32);

    // bit-clear across reserved-range edges (R5 R6)
    csStart();
    sendHeader(8'h26, 8'h78);
    for (int i = 0; i < 48; i++) begin
      a = 8'(8'h78 + i);
      d = 8'(a ^ 8'h3C);
      spiByte(d, 8, r);
      if (!isWin(a) && !isRsv(a)) expMem[a] = expMem[a] & ~d;
    end
    csStop();
    for (int i = 8'h78; i < 8'hA8; i++)
      check(rfMem[i] == expMem[i], "R5 R6 bit-clear sweep", rfMem[i], expMem[i]);

    // unknown command: inert (R1)
    sc = strobeCnt;
    csStart();
    for (int i = 0; i < 5; i++) begin
      spiByte(8'h23 + 8'(i), 8, r);
      check(r == 8'h00, "R1 miso low after unknown command", r, 0);
    end
    csStop();
    check(strobeCnt == sc, "R1 no strobe after unknown command", strobeCnt, sc);
    check(rfMem[8'h24] == expMem[8'h24], "R1 register unchanged", rfMem[8'h24], expMem[8'h24]);

    // abort mid-byte (R9)
    sc = strobeCnt;
    csStart();
    sendHeader(8'h22, 8'h30);
    spiByte(8'hA5, 8, r);
    spiByte(8'hFF, 5, r);
    csStop();
    expMem[8'h30] = 8'hA5;
    check(strobeCnt - sc == 1, "R9 partial byte discarded", strobeCnt - sc, 1);
    check(rfMem[8'h30] == 8'hA5, "R9 complete byte kept", rfMem[8'h30], 8'hA5);
    check(rfMem[8'h31] == expMem[8'h31], "R9 partial byte no write", rfMem[8'h31], expMem[8'h31]);

    // next transaction restarts at a command byte (R9)
    csStart();
    sendHeader(8'h20, 8'h30);
    spiByte(8'h00, 8, r);
    check(r == 8'hA5, "R9 fresh transaction read", r, 8'hA5);
    spiByte(8'h00, 8, r);
    check(r == expMem[8'h31], "R9 R3 fresh transaction second byte", r, expMem[8'h31]);
    csStop();
    check(spiMiso == 1'b0, "R8 miso low when deselected", spiMiso, 0);

    finishRun();
  end

endmodule